// File: doc/BRIEF.md
# Synthesizer Ratio Reconfiguration Sequencer

This block changes the multiply/divide ratio of a frequency synthesizer while the chip is running. It drives the synthesizer's configuration register port, which has address, write data, enable, write enable and ready signals. A ratio request carries the wanted multiply term M and divide term D. When the request is accepted, the block holds the clock manager in reset and writes M−1 and then D−1 to their registers. It keeps reset asserted for at least a set number of cycles, releases it, and reports completion only when the lock signal has returned.

A second kind of request writes a static phase-shift word to its own register through the same port. This request does not reset the manager and does not wait for lock. An illegal ratio is refused at once with an error pulse and nothing is written. If lock does not come back within a bounded window, the block ends the sequence with a lock error instead of a completion pulse. The register addresses, the legal ranges, the reset window and the lock window are all parameters.

Top module: `synth_ratio_seq`

## Requirements
- R1: An accepted ratio request writes M−1 to address MUL_ADDR and then D−1 to address DIV_ADDR, in that order (a request of 9/4 writes 8 and then 3), with each value zero-extended to the data width.
- R2: `mgr_rst` rises in the cycle after a ratio request is accepted. That is one cycle before the first write strobe. It stays high through both write strobes.
- R3: `mgr_rst` falls only after the second write has been acknowledged by `port_rdy`. No write strobe occurs in the last cycle of reset.
- R4: After a ratio sequence, `done` pulses high for one cycle. The pulse comes in the cycle after `mgr_locked` is first sampled high following the reset release. `mgr_rst` is low when `done` is high.
- R5: Every write raises `port_en` and `port_we` together for exactly one cycle. `port_rdy` is sampled from the cycle after the strobe onward. The next strobe follows one cycle after `port_rdy` is seen, so a ready latency of L cycles gives a strobe spacing of L+1 cycles.
- R6: A ratio request with M outside [MUL_MIN, MUL_MAX] or D outside [DIV_MIN, DIV_MAX] is rejected. Zero is always illegal. A rejected request causes `err_range` to pulse for one cycle in the next cycle. It causes no write, no reset and no busy.
- R7: `busy` is high from the cycle after acceptance until the cycle in which `done` or `err_lock` pulses, and `busy` is low in that cycle. Requests that arrive while `busy` is high are ignored. After reset, every output is low.
- R8: `mgr_rst` stays high for at least RST_MIN consecutive cycles even when both writes finish sooner. With a one-cycle ready, it is high for exactly RST_MIN cycles when RST_MIN is 6 or more.
- R9: If `mgr_locked` is not sampled high within LOCK_TO cycles after the release, `err_lock` pulses in the cycle numbered LOCK_TO+1, counting the first cycle with reset low as cycle 1. `done` is not pulsed in that sequence, and at most one of `done`, `err_range` and `err_lock` is high in any cycle.
- R10: A phase request writes `phase_in` to PHASE_ADDR without raising `mgr_rst`. `done` then pulses one cycle after `port_rdy`, with no wait for lock. If a ratio request and a phase request arrive in the same cycle, only the ratio request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_ratio | input | 1 | Ratio change request, sampled while idle |
| req_phase | input | 1 | Phase-shift write request, sampled while idle |
| mul_in | input | MW | Wanted multiply term M |
| div_in | input | DW | Wanted divide term D |
| phase_in | input | PHW | Phase-shift word |
| port_rdy | input | 1 | Write acknowledge from the configuration port |
| mgr_locked | input | 1 | Lock indication from the clock manager |
| port_en | output | 1 | Port transaction enable |
| port_we | output | 1 | Port write enable |
| port_addr | output | AW | Port register address |
| port_wdata | output | DATAW | Port write data |
| mgr_rst | output | 1 | Reset to the clock manager |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | One-cycle pulse on a rejected ratio |
| err_lock | output | 1 | One-cycle pulse on lock timeout |

## Verification
A rejection shows on `err_range` in the cycle right after the request edge. The first write strobe of a ratio request comes two cycles after the request edge, and the second comes ready latency plus one cycles after the first. Completion comes one cycle after lock is sampled high, so with a responder that raises lock five cycles into the release, `done` lands in the sixth cycle of reset-low. A lock timeout lands in cycle LOCK_TO+1. The bench samples on the falling edge, counts cycles from the last strobe and from the reset release, and compares each event against a queued expectation at exactly those distances.

// File: rtl/rcfg_seq_pkg.sv
package rcfg_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_WR_MUL,
        ST_WT_MUL,
        ST_WR_DIV,
        ST_WT_DIV,
        ST_HOLD,
        ST_LOCK,
        ST_WR_PH,
        ST_WT_PH
    } seq_state_e;

endpackage

// File: rtl/rcfg_ratio_check.sv
module rcfg_ratio_check #(
    parameter int unsigned MW      = 8,
    parameter int unsigned DW      = 8,
    parameter int unsigned DATAW   = 16,
    parameter int unsigned MUL_MIN = 2,
    parameter int unsigned MUL_MAX = 32,
    parameter int unsigned DIV_MIN = 1,
    parameter int unsigned DIV_MAX = 32
) (
    input  logic [MW-1:0]    mul_in,
    input  logic [DW-1:0]    div_in,
    output logic             legal,
    output logic [DATAW-1:0] mul_code,
    output logic [DATAW-1:0] div_code
);
    // zero is never a legal term, whatever the floor parameter says
    localparam int unsigned MUL_LO = (MUL_MIN == 0) ? 1 : MUL_MIN;
    localparam int unsigned DIV_LO = (DIV_MIN == 0) ? 1 : DIV_MIN;

    logic mul_ok;
    logic div_ok;

    always_comb begin
        mul_ok   = (32'(mul_in) >= MUL_LO) && (32'(mul_in) <= MUL_MAX);
        div_ok   = (32'(div_in) >= DIV_LO) && (32'(div_in) <= DIV_MAX);
        legal    = mul_ok && div_ok;
        mul_code = DATAW'(mul_in - MW'(1));
        div_code = DATAW'(div_in - DW'(1));
    end

endmodule

// File: rtl/rcfg_span_ctr.sv
module rcfg_span_ctr #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic hit
);
    localparam int unsigned CW     = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && (cnt_q != LIM_M1)) begin
            cnt_d = cnt_q + CW'(1);
        end
        hit = (cnt_q == LIM_M1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/synth_ratio_seq.sv
module synth_ratio_seq
    import rcfg_seq_pkg::*;
#(
    parameter int unsigned MW         = 8,
    parameter int unsigned DW         = 8,
    parameter int unsigned PHW        = 8,
    parameter int unsigned AW         = 7,
    parameter int unsigned DATAW      = 16,
    parameter int unsigned MUL_MIN    = 2,
    parameter int unsigned MUL_MAX    = 32,
    parameter int unsigned DIV_MIN    = 1,
    parameter int unsigned DIV_MAX    = 32,
    parameter int unsigned MUL_ADDR   = 'h50,
    parameter int unsigned DIV_ADDR   = 'h52,
    parameter int unsigned PHASE_ADDR = 'h55,
    parameter int unsigned RST_MIN    = 8,
    parameter int unsigned LOCK_TO    = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_ratio,
    input  logic             req_phase,
    input  logic [MW-1:0]    mul_in,
    input  logic [DW-1:0]    div_in,
    input  logic [PHW-1:0]   phase_in,
    input  logic             port_rdy,
    input  logic             mgr_locked,
    output logic             port_en,
    output logic             port_we,
    output logic [AW-1:0]    port_addr,
    output logic [DATAW-1:0] port_wdata,
    output logic             mgr_rst,
    output logic             busy,
    output logic             done,
    output logic             err_range,
    output logic             err_lock
);
    localparam logic [AW-1:0] A_MUL = AW'(MUL_ADDR);
    localparam logic [AW-1:0] A_DIV = AW'(DIV_ADDR);
    localparam logic [AW-1:0] A_PH  = AW'(PHASE_ADDR);

    typedef struct packed {
        seq_state_e       st;
        logic [DATAW-1:0] mul_w;
        logic [DATAW-1:0] div_w;
        logic [DATAW-1:0] ph_w;
        logic             done;
        logic             err_range;
        logic             err_lock;
    } seq_t;

    seq_t             seq_d;
    seq_t             seq_q;
    logic             legal;
    logic [DATAW-1:0] mul_code;
    logic [DATAW-1:0] div_code;
    logic             rst_hit;
    logic             lock_hit;
    logic             win_clr;
    logic             lock_run;

    rcfg_ratio_check #(
        .MW(MW), .DW(DW), .DATAW(DATAW),
        .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX),
        .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
    ) u_check (
        .mul_in  (mul_in),
        .div_in  (div_in),
        .legal   (legal),
        .mul_code(mul_code),
        .div_code(div_code)
    );

    // counts reset-high cycles from the first one
    rcfg_span_ctr #(.LIMIT(RST_MIN)) u_rst_win (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (win_clr),
        .run  (mgr_rst),
        .hit  (rst_hit)
    );

    // counts cycles spent waiting for lock
    rcfg_span_ctr #(.LIMIT(LOCK_TO)) u_lock_win (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!lock_run),
        .run  (lock_run),
        .hit  (lock_hit)
    );

    always_comb begin
        win_clr  = (seq_q.st == ST_IDLE);
        lock_run = (seq_q.st == ST_LOCK);
        mgr_rst  = seq_q.st inside {ST_PRE, ST_WR_MUL, ST_WT_MUL,
                                    ST_WR_DIV, ST_WT_DIV, ST_HOLD};
        busy      = (seq_q.st != ST_IDLE);
        done      = seq_q.done;
        err_range = seq_q.err_range;
        err_lock  = seq_q.err_lock;

        port_en    = 1'b0;
        port_addr  = '0;
        port_wdata = '0;
        unique case (seq_q.st)
            ST_WR_MUL: begin
                port_en    = 1'b1;
                port_addr  = A_MUL;
                port_wdata = seq_q.mul_w;
            end
            ST_WR_DIV: begin
                port_en    = 1'b1;
                port_addr  = A_DIV;
                port_wdata = seq_q.div_w;
            end
            ST_WR_PH: begin
                port_en    = 1'b1;
                port_addr  = A_PH;
                port_wdata = seq_q.ph_w;
            end
            default: ;
        endcase
        port_we = port_en;
    end

    always_comb begin
        seq_d           = seq_q;
        seq_d.done      = 1'b0;
        seq_d.err_range = 1'b0;
        seq_d.err_lock  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_ratio) begin
                    if (legal) begin
                        seq_d.mul_w = mul_code;
                        seq_d.div_w = div_code;
                        seq_d.st    = ST_PRE;
                    end else begin
                        seq_d.err_range = 1'b1;
                    end
                end else if (req_phase) begin
                    seq_d.ph_w = DATAW'(phase_in);
                    seq_d.st   = ST_WR_PH;
                end
            end
            ST_PRE:    seq_d.st = ST_WR_MUL;
            ST_WR_MUL: seq_d.st = ST_WT_MUL;
            ST_WT_MUL: if (port_rdy) seq_d.st = ST_WR_DIV;
            ST_WR_DIV: seq_d.st = ST_WT_DIV;
            ST_WT_DIV: if (port_rdy) seq_d.st = ST_HOLD;
            ST_HOLD:   if (rst_hit) seq_d.st = ST_LOCK;
            ST_LOCK: begin
                if (mgr_locked) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else if (lock_hit) begin
                    seq_d.st       = ST_IDLE;
                    seq_d.err_lock = 1'b1;
                end
            end
            ST_WR_PH:  seq_d.st = ST_WT_PH;
            ST_WT_PH: begin
                if (port_rdy) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default:   seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/synth_ratio_seq_chk.sv
module synth_ratio_seq_chk #(
    parameter int unsigned RST_MIN = 8
) (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic port_we,
    input logic mgr_rst,
    input logic busy,
    input logic done,
    input logic err_range,
    input logic err_lock
);
    int unsigned win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= 0;
        end else if (mgr_rst) begin
            win_q <= win_q + 1;
        end else begin
            win_q <= 0;
        end
    end

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> !port_en);

    a_r5_strobe_we: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> port_we);

    a_r3_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mgr_rst) |-> !$past(port_en));

    a_r4_done_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mgr_rst);

    a_r6_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> (!busy && !mgr_rst && !port_en));

    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_lock) |-> !busy);

    a_r8_reset_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mgr_rst) |-> (win_q >= RST_MIN));

    a_r9_outcome_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_range, err_lock}));

endmodule

bind synth_ratio_seq synth_ratio_seq_chk #(.RST_MIN(RST_MIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .port_we  (port_we),
    .mgr_rst  (mgr_rst),
    .busy     (busy),
    .done     (done),
    .err_range(err_range),
    .err_lock (err_lock)
);

// File: tb/tb_synth_ratio_seq.sv
module tb_synth_ratio_seq;

    localparam int MW = 8, DW = 8, PHW = 8, AW = 7, DATAW = 16;
    localparam int MUL_MIN = 2, MUL_MAX = 32, DIV_MIN = 1, DIV_MAX = 32;
    localparam int MUL_ADDR = 'h50, DIV_ADDR = 'h52, PHASE_ADDR = 'h55;
    localparam int RST_MIN = 8, LOCK_TO = 40, LOCK_LAT = 5;

    localparam int K_WR = 0, K_DONE = 1, K_ERNG = 2, K_ELCK = 3;

    typedef struct {
        int    kind;
        int    addr;
        int    data;
        bit    rst;
        bit    rst_prev;
        int    gap;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_ratio, req_phase;
    logic [MW-1:0]    mul_in;
    logic [DW-1:0]    div_in;
    logic [PHW-1:0]   phase_in;
    logic             port_rdy, mgr_locked;
    logic             port_en, port_we, mgr_rst, busy, done, err_range, err_lock;
    logic [AW-1:0]    port_addr;
    logic [DATAW-1:0] port_wdata;

    exp_t q_exp[$];
    int   checks = 0, fails = 0;
    int   cur_rlat = 1;
    bit   lock_ok = 1'b1;
    int   cyc = 0;

    synth_ratio_seq #(
        .MW(MW), .DW(DW), .PHW(PHW), .AW(AW), .DATAW(DATAW),
        .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
        .MUL_ADDR(MUL_ADDR), .DIV_ADDR(DIV_ADDR), .PHASE_ADDR(PHASE_ADDR),
        .RST_MIN(RST_MIN), .LOCK_TO(LOCK_TO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_ratio(req_ratio), .req_phase(req_phase),
        .mul_in(mul_in), .div_in(div_in), .phase_in(phase_in),
        .port_rdy(port_rdy), .mgr_locked(mgr_locked),
        .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
        .port_wdata(port_wdata), .mgr_rst(mgr_rst), .busy(busy), .done(done),
        .err_range(err_range), .err_lock(err_lock)
    );

    always #2.5ns clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic push(input int kind, input int addr, input int data,
                        input bit rst, input bit rst_prev, input int gap, input string tag);
        exp_t it;
        it.kind = kind; it.addr = addr; it.data = data;
        it.rst = rst; it.rst_prev = rst_prev; it.gap = gap; it.tag = tag;
        q_exp.push_back(it);
    endtask

    // configuration-port and clock-manager responder
    initial begin : responder
        int rdy_cnt = 0;
        int lk_cnt = 0;
        port_rdy   = 1'b0;
        mgr_locked = 1'b1;
        forever begin
            @(negedge clk);
            port_rdy = 1'b0;
            if (rdy_cnt > 0) begin
                rdy_cnt--;
                if (rdy_cnt == 0) port_rdy = 1'b1;
            end
            if (port_en) rdy_cnt = cur_rlat;
            if (mgr_rst) begin
                mgr_locked = 1'b0;
                lk_cnt     = LOCK_LAT;
            end else if (lk_cnt > 0) begin
                lk_cnt--;
                if (lk_cnt == 0 && lock_ok) mgr_locked = 1'b1;
            end
        end
    end

    // monitor: pops expectations as events appear
    initial begin : monitor
        int  since = 0;
        int  run = 0;
        int  last_wr = 0;
        bit  last_rst = 1'b0;
        exp_t it;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                finish_run();
            end
            if (rst_n) begin
                if (!mgr_rst && last_rst) since = 1; else since++;
                if (port_en) begin
                    chk(port_we, "R5 write enable with strobe", port_we, 1);
                    if (q_exp.size() == 0) chk(0, "R7 unexpected write", port_addr, -1);
                    else begin
                        it = q_exp.pop_front();
                        chk(it.kind == K_WR, {it.tag, " event kind"}, K_WR, it.kind);
                        chk(port_addr == AW'(it.addr), {it.tag, " address"}, port_addr, it.addr);
                        chk(port_wdata == DATAW'(it.data), {it.tag, " data"}, port_wdata, it.data);
                        chk(mgr_rst == it.rst, "R2 reset level at write", mgr_rst, it.rst);
                        chk(last_rst == it.rst_prev, "R2 reset before write", last_rst, it.rst_prev);
                        if (it.gap > 0)
                            chk(cyc - last_wr == it.gap, "R5 strobe spacing", cyc - last_wr, it.gap);
                    end
                    last_wr = cyc;
                end
                if (done) begin
                    if (q_exp.size() == 0) chk(0, "R4 unexpected done", 1, 0);
                    else begin
                        it = q_exp.pop_front();
                        chk(it.kind == K_DONE, {it.tag, " done kind"}, K_DONE, it.kind);
                        chk(!busy, "R7 busy low at done", busy, 0);
                        if (it.rst) begin
                            chk(mgr_locked, "R4 locked at done", mgr_locked, 1);
                            chk(since == it.data, "R4 done timing", since, it.data);
                        end
                    end
                end
                if (err_range) begin
                    if (q_exp.size() == 0) chk(0, "R6 unexpected err_range", 1, 0);
                    else begin
                        it = q_exp.pop_front();
                        chk(it.kind == K_ERNG, {it.tag, " err_range kind"}, K_ERNG, it.kind);
                        chk(!busy && !mgr_rst, "R6 idle on reject", busy, 0);
                    end
                end
                if (err_lock) begin
                    if (q_exp.size() == 0) chk(0, "R9 unexpected err_lock", 1, 0);
                    else begin
                        it = q_exp.pop_front();
                        chk(it.kind == K_ELCK, {it.tag, " err_lock kind"}, K_ELCK, it.kind);
                        chk(since == LOCK_TO + 1, "R9 timeout cycle", since, LOCK_TO + 1);
                    end
                end
                if (mgr_rst) run++;
                else if (run > 0) begin
                    chk(run >= RST_MIN, "R8 reset window", run, RST_MIN);
                    if (cur_rlat == 1)
                        chk(run == RST_MIN, "R8 exact window", run, RST_MIN);
                    run = 0;
                end
                last_rst = mgr_rst;
            end
        end
    end

    task automatic drain(input string tag);
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(q_exp.size() == 0, {tag, " all events seen"}, q_exp.size(), 0);
    endtask

    task automatic ratio(input int m, input int d, input bit lk, input int rlat,
                         input bit poke, input bit both);
        bit legal = (m >= MUL_MIN) && (m <= MUL_MAX) && (d >= DIV_MIN) && (d <= DIV_MAX);
        cur_rlat = rlat;
        lock_ok  = lk;
        if (legal) begin
            push(K_WR, MUL_ADDR, m - 1, 1'b1, 1'b1, 0, "R1 multiply write");
            push(K_WR, DIV_ADDR, d - 1, 1'b1, 1'b1, rlat + 1, "R1 divide write");
            if (lk) push(K_DONE, 0, LOCK_LAT + 1, 1'b1, 1'b0, 0, "R4");
            else    push(K_ELCK, 0, 0, 1'b0, 1'b0, 0, "R9");
        end else begin
            push(K_ERNG, 0, 0, 1'b0, 1'b0, 0, "R6");
        end
        @(negedge clk);
        req_ratio = 1'b1;
        req_phase = both;
        phase_in  = 8'h3C;
        mul_in    = MW'(m);
        div_in    = DW'(d);
        @(negedge clk);
        req_ratio = 1'b0;
        req_phase = 1'b0;
        if (legal) chk(busy, "R7 busy after accept", busy, 1);
        else       chk(!busy && !mgr_rst, "R6 no busy on reject", busy, 0);
        if (poke) begin
            @(negedge clk);
            req_ratio = 1'b1;
            req_phase = 1'b1;
            mul_in    = 8'd5;
            div_in    = 8'd7;
            @(negedge clk);
            req_ratio = 1'b0;
            req_phase = 1'b0;
        end
        drain(legal ? "R1" : "R6");
    endtask

    task automatic phase(input int p);
        cur_rlat = 2;
        push(K_WR, PHASE_ADDR, p, 1'b0, 1'b0, 0, "R10 phase write");
        push(K_DONE, 0, 0, 1'b0, 1'b0, 0, "R10");
        @(negedge clk);
        req_phase = 1'b1;
        phase_in  = PHW'(p);
        @(negedge clk);
        req_phase = 1'b0;
        chk(busy && !mgr_rst, "R10 busy without reset", mgr_rst, 0);
        drain("R10");
    endtask

    initial begin : main
        rst_n     = 1'b0;
        req_ratio = 1'b0;
        req_phase = 1'b0;
        mul_in    = '0;
        div_in    = '0;
        phase_in  = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !mgr_rst && !port_en && !done && !err_range && !err_lock,
            "R7 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mgr_rst && !port_en, "R7 idle after reset", busy, 0);

        ratio(9, 4, 1'b1, 1, 1'b0, 1'b0);       // R1 example: 8 then 3
        ratio(32, 32, 1'b1, 3, 1'b0, 1'b0);     // R6 upper bound legal, slow ready R5
        ratio(2, 1, 1'b1, 1, 1'b0, 1'b0);       // lower bounds legal
        ratio(0, 4, 1'b1, 1, 1'b0, 1'b0);       // R6 zero multiply
        ratio(9, 0, 1'b1, 1, 1'b0, 1'b0);       // R6 zero divide
        ratio(33, 4, 1'b1, 1, 1'b0, 1'b0);      // R6 over max
        ratio(9, 33, 1'b1, 1, 1'b0, 1'b0);
        ratio(1, 4, 1'b1, 1, 1'b0, 1'b0);       // R6 under MUL_MIN
        phase('hA5);                            // R10
        phase(0);
        ratio(12, 5, 1'b1, 2, 1'b1, 1'b0);      // R7 requests ignored while busy
        ratio(6, 3, 1'b1, 1, 1'b0, 1'b1);       // R10 ratio wins over phase
        ratio(7, 3, 1'b0, 1, 1'b0, 1'b0);       // R9 lock timeout
        ratio(7, 3, 1'b1, 1, 1'b0, 1'b0);       // recovery after timeout

        chk(q_exp.size() == 0, "R7 scoreboard empty", q_exp.size(), 0);
        finish_run();
    end

endmodule